// File: doc/BRIEF.md
# Receive Mailbox Allocator With Overwrite Protection

This block sits behind a CAN bit-level receiver. Each time the receiver finishes a frame, it presents the identifier, the length code and eight data bytes for one cycle. The block searches a bank of receive mailboxes for a slot to hold the frame and stores it there. Each mailbox holds an identifier word, a control word and two data words. Each mailbox also has its own acceptance mask, and a global mask is shared by all of them. The block keeps per-mailbox pending, message-lost and overwrite-protection bits and drives two interrupt lines.

The search gives priority to mailbox number. The frame goes to the highest-numbered mailbox that is enabled, set to the receive direction and whose filter accepts the identifier. A mailbox that still holds an unread frame and has overwrite protection set is passed over, and the search moves on to the next lower candidate. A pending mailbox without protection is overwritten, and its lost bit records the loss. If every accepting mailbox is protected and pending, the frame is discarded and the loss is recorded.

A register-mapped CPU port configures the filters and reads mailbox contents. It also clears pending and lost bits by writing ones to them. Reads return data one cycle after the request.

Top module: `rx_mailbox_alloc`

## Requirements
- R1: A stored frame goes into the highest-numbered mailbox that is enabled, has its direction bit at 1 (receive) and accepts the identifier.
- R2: A mailbox accepts an identifier when every identifier bit equals the stored identifier, except don't-care bits. When the mask-enable bit (bit 31 of the identifier word) is 1, the don't-care bits are the ones set in the local mask OR the global mask. When that bit is 0, no bit is a don't-care.
- R3: Storing a frame sets the pending bit of the chosen mailbox (register 2). Writing a 1 to a pending bit clears it, and writing a 0 leaves it unchanged.
- R4: Storing a frame writes the identifier into bits ID_W-1:0 of word 0, keeping bit 31. It writes the length code into bits 3:0 of word 1. Word 2 holds byte0..byte3 and word 3 holds byte4..byte7, in both cases with the lower byte number in the more significant position. Byte k arrives on rx_data[8k+7:8k].
- R5: A mailbox that is pending and has its protection bit set (register 4) is skipped, and the search continues to lower mailboxes.
- R6: A pending mailbox without protection that is selected is overwritten, and its lost bit (register 3, write 1 to clear) is set.
- R7: When the only accepting mailboxes are pending and protected, the frame is discarded. The lost bit of the highest accepting mailbox is set, and no pending bit or mailbox content changes.
- R8: A mailbox whose enable bit (register 0) is 0 or whose direction bit (register 1) is 0 is never chosen, even if its filter accepts.
- R9: A frame that no eligible mailbox accepts changes no pending bit and no lost bit.
- R10: mb_irq equals the OR of pending AND interrupt mask (register 5), and lost_irq equals the OR of the lost bits. Both lag the register state by one cycle.
- R11: The CPU address map is as follows. Global registers 0..6 are at the addresses whose top two bits are 00: enable, direction, pending, lost, protect, irq mask, global mask. Local masks are at top bits 01, with the low MBW bits selecting the mailbox. Mailbox words are at top bit 1, with the mailbox in bits AW-2:2 and the word in bits 1:0. cpu_rdata is valid one cycle after cpu_rd.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Completed frame present this cycle |
| rx_id | input | ID_W | Frame identifier |
| rx_dlc | input | 4 | Length code |
| rx_data | input | 64 | Data bytes, byte k at bits 8k+7:8k |
| cpu_wr | input | 1 | Register write strobe |
| cpu_rd | input | 1 | Register read strobe |
| cpu_addr | input | AW | Register address |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Read data, one cycle after cpu_rd |
| mb_irq | output | 1 | Pending mailbox interrupt |
| lost_irq | output | 1 | Lost message interrupt |

## Verification
The bench builds the block with eight mailboxes and 11-bit identifiers. With eight mailboxes, a few frames are enough to fill every receive mailbox and reach the case where all accepting mailboxes are protected and pending. The bench also keeps transmit-direction mailboxes that would accept every frame, so a wrong choice would show up in the pending register. With 11-bit identifiers, identifier values can be picked so that only the global mask joins a mask-enabled mailbox to a frame, while a mailbox with masking off rejects the same frame.

// File: rtl/rx_mailbox_pkg.sv
package rx_mailbox_pkg;
  typedef enum logic [2:0] {
    GR_ENABLE = 3'd0,
    GR_DIR    = 3'd1,
    GR_PEND   = 3'd2,
    GR_LOST   = 3'd3,
    GR_PROT   = 3'd4,
    GR_IMASK  = 3'd5,
    GR_GMASK  = 3'd6
  } glb_reg_e;

  localparam int PAYLOAD_W = 4 + 64;
  localparam int MASK_EN_BIT = 31;
endpackage

// File: rtl/rx_mailbox_filter.sv
module rx_mailbox_filter #(
  parameter int NUM_MB = 32,
  parameter int ID_W   = 29
) (
  input  logic [ID_W-1:0]              rx_id,
  input  logic [NUM_MB-1:0][ID_W-1:0]  mb_id,
  input  logic [NUM_MB-1:0][ID_W-1:0]  mb_mask,
  input  logic [NUM_MB-1:0]            mb_mask_en,
  input  logic [ID_W-1:0]              glb_mask,
  input  logic [NUM_MB-1:0]            mb_en,
  input  logic [NUM_MB-1:0]            mb_dir,
  output logic [NUM_MB-1:0]            hit
);
  for (genvar g = 0; g < NUM_MB; g++) begin : g_mb
    logic [ID_W-1:0] dont_care;
    assign dont_care = mb_mask_en[g] ? (mb_mask[g] | glb_mask) : '0;
    assign hit[g] = mb_en[g] & mb_dir[g] &
                    (((rx_id ^ mb_id[g]) & ~dont_care) == '0);
  end
endmodule

// File: rtl/rx_mailbox_pick.sv
module rx_mailbox_pick #(
  parameter int N = 32,
  localparam int W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0] req,
  output logic         any,
  output logic [W-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i]) begin
        any = 1'b1;
        idx = W'(i);
      end
    end
  end
endmodule

// File: rtl/rx_mailbox_ram.sv
module rx_mailbox_ram #(
  parameter int DEPTH = 32,
  parameter int DW    = 68,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/rx_mailbox_alloc.sv
module rx_mailbox_alloc
  import rx_mailbox_pkg::*;
#(
  parameter int NUM_MB = 32,
  parameter int ID_W   = 29,
  localparam int MBW   = $clog2(NUM_MB),
  localparam int AW    = MBW + 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            rx_valid,
  input  logic [ID_W-1:0] rx_id,
  input  logic [3:0]      rx_dlc,
  input  logic [63:0]     rx_data,
  input  logic            cpu_wr,
  input  logic            cpu_rd,
  input  logic [AW-1:0]   cpu_addr,
  input  logic [31:0]     cpu_wdata,
  output logic [31:0]     cpu_rdata,
  output logic            mb_irq,
  output logic            lost_irq
);
  logic [NUM_MB-1:0] en_r, dir_r, pend_r, lost_r, prot_r, imask_r;
  logic [NUM_MB-1:0] pend_nx, lost_nx;
  logic [ID_W-1:0]   gmask_r;
  logic [NUM_MB-1:0][ID_W-1:0] mid_r, lam_r;
  logic [NUM_MB-1:0] ame_r;

  // address decode
  logic           sel_glb, sel_lam, sel_mbx;
  glb_reg_e       greg;
  logic [MBW-1:0] lam_idx, mbx_idx;
  logic [1:0]     mbx_word;
  assign sel_glb  = (cpu_addr[AW-1:AW-2] == 2'b00);
  assign sel_lam  = (cpu_addr[AW-1:AW-2] == 2'b01);
  assign sel_mbx  = cpu_addr[AW-1];
  assign greg     = glb_reg_e'(cpu_addr[2:0]);
  assign lam_idx  = cpu_addr[MBW-1:0];
  assign mbx_idx  = cpu_addr[AW-2:2];
  assign mbx_word = cpu_addr[1:0];

  // search
  logic [NUM_MB-1:0] hit, take;
  logic              any_take, any_hit;
  logic [MBW-1:0]    idx_take, idx_hit;
  logic              do_store, do_lose;

  rx_mailbox_filter #(.NUM_MB(NUM_MB), .ID_W(ID_W)) u_filter (
    .rx_id(rx_id), .mb_id(mid_r), .mb_mask(lam_r), .mb_mask_en(ame_r),
    .glb_mask(gmask_r), .mb_en(en_r), .mb_dir(dir_r), .hit(hit)
  );

  assign take = hit & ~(pend_r & prot_r);

  rx_mailbox_pick #(.N(NUM_MB)) u_pick_take (.req(take), .any(any_take), .idx(idx_take));
  rx_mailbox_pick #(.N(NUM_MB)) u_pick_hit  (.req(hit),  .any(any_hit),  .idx(idx_hit));

  assign do_store = rx_valid & any_take;
  assign do_lose  = rx_valid & ~any_take & any_hit;

  // payload storage
  logic [31:0] word_lo, word_hi;
  logic [PAYLOAD_W-1:0] ram_q;
  assign word_lo = {rx_data[7:0],   rx_data[15:8],  rx_data[23:16], rx_data[31:24]};
  assign word_hi = {rx_data[39:32], rx_data[47:40], rx_data[55:48], rx_data[63:56]};

  rx_mailbox_ram #(.DEPTH(NUM_MB), .DW(PAYLOAD_W)) u_ram (
    .clk(clk), .we(do_store), .waddr(idx_take),
    .wdata({rx_dlc, word_hi, word_lo}), .raddr(mbx_idx), .rdata(ram_q)
  );

  // pending / lost next state: CPU clear first, hardware set wins
  always_comb begin
    pend_nx = pend_r;
    lost_nx = lost_r;
    if (cpu_wr && sel_glb && greg == GR_PEND) pend_nx = pend_nx & ~cpu_wdata[NUM_MB-1:0];
    if (cpu_wr && sel_glb && greg == GR_LOST) lost_nx = lost_nx & ~cpu_wdata[NUM_MB-1:0];
    if (do_store) begin
      pend_nx[idx_take] = 1'b1;
      if (pend_r[idx_take]) lost_nx[idx_take] = 1'b1;
    end
    if (do_lose) lost_nx[idx_hit] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_r <= '0; dir_r <= '0; pend_r <= '0; lost_r <= '0;
      prot_r <= '0; imask_r <= '0; gmask_r <= '0;
      mid_r <= '0; lam_r <= '0; ame_r <= '0;
      mb_irq <= 1'b0; lost_irq <= 1'b0;
    end else begin
      pend_r <= pend_nx;
      lost_r <= lost_nx;
      if (cpu_wr && sel_glb) begin
        case (greg)
          GR_ENABLE: en_r    <= cpu_wdata[NUM_MB-1:0];
          GR_DIR:    dir_r   <= cpu_wdata[NUM_MB-1:0];
          GR_PROT:   prot_r  <= cpu_wdata[NUM_MB-1:0];
          GR_IMASK:  imask_r <= cpu_wdata[NUM_MB-1:0];
          GR_GMASK:  gmask_r <= cpu_wdata[ID_W-1:0];
          default: ;
        endcase
      end
      if (cpu_wr && sel_lam) lam_r[lam_idx] <= cpu_wdata[ID_W-1:0];
      if (cpu_wr && sel_mbx && mbx_word == 2'd0) begin
        mid_r[mbx_idx] <= cpu_wdata[ID_W-1:0];
        ame_r[mbx_idx] <= cpu_wdata[MASK_EN_BIT];
      end
      if (do_store) mid_r[idx_take] <= rx_id;
      mb_irq   <= |(pend_r & imask_r);
      lost_irq <= |lost_r;
    end
  end

  // read path
  logic        rd_ram;
  logic [1:0]  rd_word;
  logic [31:0] rd_reg, reg_mux;

  always_comb begin
    reg_mux = '0;
    if (sel_mbx) begin
      reg_mux = 32'(mid_r[mbx_idx]);
      reg_mux[MASK_EN_BIT] = ame_r[mbx_idx];
    end else if (sel_lam) begin
      reg_mux = 32'(lam_r[lam_idx]);
    end else begin
      case (greg)
        GR_ENABLE: reg_mux = 32'(en_r);
        GR_DIR:    reg_mux = 32'(dir_r);
        GR_PEND:   reg_mux = 32'(pend_r);
        GR_LOST:   reg_mux = 32'(lost_r);
        GR_PROT:   reg_mux = 32'(prot_r);
        GR_IMASK:  reg_mux = 32'(imask_r);
        GR_GMASK:  reg_mux = 32'(gmask_r);
        default:   reg_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ram <= 1'b0; rd_word <= '0; rd_reg <= '0;
    end else if (cpu_rd) begin
      rd_ram  <= sel_mbx && (mbx_word != 2'd0);
      rd_word <= mbx_word;
      rd_reg  <= reg_mux;
    end
  end

  always_comb begin
    if (!rd_ram)             cpu_rdata = rd_reg;
    else if (rd_word == 2'd1) cpu_rdata = {28'd0, ram_q[67:64]};
    else if (rd_word == 2'd2) cpu_rdata = ram_q[31:0];
    else                      cpu_rdata = ram_q[63:32];
  end

  // R1
  chosen_eligible_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && any_take) |-> (en_r[idx_take] && dir_r[idx_take] && hit[idx_take]));
  // R5
  protected_kept_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && any_take) |-> !(pend_r[idx_take] && prot_r[idx_take]));
  // R3
  single_pend_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(pend_r & ~$past(pend_r)) <= 1);
  // R3
  pend_needs_frame_chk: assert property (@(posedge clk) disable iff (rst)
    (|(pend_r & ~$past(pend_r))) |-> $past(rx_valid));
  // R6
  lost_needs_frame_chk: assert property (@(posedge clk) disable iff (rst)
    (|(lost_r & ~$past(lost_r))) |-> $past(rx_valid));
  // R10
  lost_irq_lag_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(lost_irq) |-> $past(|lost_r));
endmodule

// File: tb/rx_mailbox_alloc_tb.sv
module rx_mailbox_alloc_tb_top;
  localparam int NMB = 8;
  localparam int IDW = 11;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_valid = 1'b0;
  logic [IDW-1:0] rx_id = '0;
  logic [3:0] rx_dlc = '0;
  logic [63:0] rx_data = '0;
  logic cpu_wr = 1'b0, cpu_rd = 1'b0;
  logic [5:0] cpu_addr = '0;
  logic [31:0] cpu_wdata = '0;
  logic [31:0] cpu_rdata;
  logic mb_irq, lost_irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  rx_mailbox_alloc #(.NUM_MB(NMB), .ID_W(IDW)) dut_i (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_id(rx_id), .rx_dlc(rx_dlc),
    .rx_data(rx_data), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .mb_irq(mb_irq), .lost_irq(lost_irq)
  );

  localparam logic [5:0] A_EN = 6'd0, A_DIR = 6'd1, A_PEND = 6'd2, A_LOST = 6'd3,
                         A_PROT = 6'd4, A_IMASK = 6'd5, A_GMASK = 6'd6;
  function automatic logic [5:0] a_lam(int i); return 6'(16 + i); endfunction
  function automatic logic [5:0] a_mb(int i, int w); return 6'(32 + 4*i + w); endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk); cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk); cpu_wr = 1'b0;
  endtask

  task automatic rd(logic [5:0] a, output logic [31:0] d);
    @(negedge clk); cpu_rd = 1'b1; cpu_addr = a;
    @(negedge clk); cpu_rd = 1'b0; d = cpu_rdata;
  endtask

  task automatic rd_chk(string req, logic [5:0] a, logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic frame(logic [IDW-1:0] id, logic [3:0] dlc, logic [63:0] d);
    @(negedge clk); rx_valid = 1'b1; rx_id = id; rx_dlc = dlc; rx_data = d;
    @(negedge clk); rx_valid = 1'b0;
  endtask

  task automatic t_reset;
    chk("R10 reset mb_irq", 32'(mb_irq), 0);
    chk("R10 reset lost_irq", 32'(lost_irq), 0);
    rd_chk("R3 reset pending", A_PEND, 0);
    rd_chk("R6 reset lost", A_LOST, 0);
  endtask

  task automatic t_setup;
    wr(A_EN, 32'hFF);
    wr(A_DIR, 32'hF0);
    wr(a_mb(7, 0), 32'h8000_0000); wr(a_lam(7), 32'h7FF);
    wr(a_mb(6, 0), 32'h8000_0000); wr(a_lam(6), 32'h7FF);
    wr(a_mb(5, 0), 32'h0000_0123); wr(a_lam(5), 32'h7FF);
    wr(a_mb(4, 0), 32'h8000_0120); wr(a_lam(4), 32'h00F);
    wr(a_mb(3, 0), 32'h8000_0000); wr(a_lam(3), 32'h7FF);
    rd_chk("R11 dir readback", A_DIR, 32'hF0);
  endtask

  task automatic t_store;
    // bytes 0..7 = 11..88, byte k at [8k+7:8k]
    frame(11'h123, 4'd8, 64'h8877_6655_4433_2211);
    rd_chk("R1 highest match pending", A_PEND, 32'h80);
    rd_chk("R4 low word", a_mb(7, 2), 32'h1122_3344);
    rd_chk("R4 high word", a_mb(7, 3), 32'h5566_7788);
    rd_chk("R4 length", a_mb(7, 1), 32'd8);
    rd_chk("R4 id word", a_mb(7, 0), 32'h8000_0123);
  endtask

  task automatic t_overwrite;
    frame(11'h0AB, 4'd2, 64'h0000_0000_0000_A2A1);
    rd_chk("R6 pending kept", A_PEND, 32'h80);
    rd_chk("R6 lost bit", A_LOST, 32'h80);
    chk("R10 lost_irq high", 32'(lost_irq), 1);
    rd_chk("R6 data replaced", a_mb(7, 2), 32'hA1A2_0000);
    rd_chk("R6 id replaced", a_mb(7, 0), 32'h8000_00AB);
  endtask

  task automatic t_w1c;
    wr(A_PEND, 32'h7F);
    rd_chk("R3 write zero keeps", A_PEND, 32'h80);
    wr(A_PEND, 32'h80);
    wr(A_LOST, 32'h80);
    rd_chk("R3 pending cleared", A_PEND, 0);
    rd_chk("R6 lost cleared", A_LOST, 0);
    chk("R10 lost_irq low", 32'(lost_irq), 0);
  endtask

  task automatic t_protect;
    wr(A_PROT, 32'hF0);
    frame(11'h001, 4'd1, 64'h0);
    frame(11'h002, 4'd1, 64'h0);
    rd_chk("R5 skip to mb6", A_PEND, 32'hC0);
    frame(11'h123, 4'd1, 64'h0);
    rd_chk("R5 exact mb5", A_PEND, 32'hE0);
    frame(11'h12A, 4'd1, 64'h0);
    rd_chk("R2 local mask mb4", A_PEND, 32'hF0);
    rd_chk("R4 mb4 id", a_mb(4, 0), 32'h8000_012A);
    frame(11'h12A, 4'd3, 64'hFFFF);
    rd_chk("R7 pending unchanged", A_PEND, 32'hF0);
    rd_chk("R7 lost at highest match", A_LOST, 32'h80);
    rd_chk("R7 mb7 untouched", a_mb(7, 0), 32'h8000_0001);
    rd_chk("R7 mb4 length untouched", a_mb(4, 1), 32'd1);
    wr(A_PEND, 32'hF0); wr(A_LOST, 32'hFF);
  endtask

  task automatic t_disable;
    wr(A_EN, 32'h7F);
    frame(11'h3C3, 4'd0, 64'h0);
    rd_chk("R8 disabled mb7 skipped", A_PEND, 32'h40);
    wr(A_PEND, 32'hFF);
  endtask

  task automatic t_nomatch;
    wr(A_EN, 32'h3F);
    frame(11'h555, 4'd0, 64'h0);
    rd_chk("R9 no pending", A_PEND, 0);
    rd_chk("R9 no lost", A_LOST, 0);
  endtask

  task automatic t_gmask;
    wr(A_GMASK, 32'h470);
    frame(11'h553, 4'd0, 64'h0);
    rd_chk("R2 global mask only with enable", A_PEND, 32'h10);
    rd_chk("R11 gmask readback", A_GMASK, 32'h470);
  endtask

  task automatic t_irq;
    chk("R10 mb_irq masked", 32'(mb_irq), 0);
    wr(A_IMASK, 32'h10);
    @(negedge clk);
    chk("R10 mb_irq raised", 32'(mb_irq), 1);
    wr(A_IMASK, 32'h20);
    @(negedge clk);
    chk("R10 mb_irq dropped", 32'(mb_irq), 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_setup();
    t_store();
    t_overwrite();
    t_w1c();
    t_protect();
    t_disable();
    t_nomatch();
    t_gmask();
    t_irq();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule